// File: doc/BRIEF.md
# Dual-Bus Arbiter with Backoff

This block decides ownership of two linked buses: a processor-side bus and a PCI-side bus. The processor is the default owner of its bus. The host bridge is the default owner of the PCI bus. A small set of external PCI masters compete for the PCI bus, and the winner is picked round-robin. A configuration bit selects one of two modes. In the joined mode, the two buses behave as a single bus. An external master first has the bridge take the processor bus on its behalf, and only then receives the PCI bus. In the split mode, the PCI side arbitrates on its own while the processor keeps its bus.

The joined mode has one exception, which exists to break an ordering deadlock. The processor may be parked on its bus waiting to retry a PCI target that turned it away. If an external master asks to write memory during that wait, the arbiter pushes the processor off with a backoff signal and grants the master at once. Once the write is over, backoff is released, and the bridge then re-runs the processor's interrupted access. A read request in the same situation simply waits.

Mode changes are deferred until both buses are quiet. An output tells the bridge to stop posting processor writes whenever the joined mode is selected or pending.

Top module: `dual_bus_arbiter`

## Requirements
- R1: Out of reset, and whenever nothing requests, cpu_gnt=1 and hb_pci_gnt=1, while hb_cpu_gnt=0, ext_gnt=0 and cpu_boff=0. The active mode resets to split (mode_sel: 1 = joined, 0 = split).
- R2: In joined mode, an external request seen while cpu_req=0 and hb_req=0 raises hb_cpu_gnt (and drops cpu_gnt) one clock later. The ext_gnt bit of the winner rises one clock after that, while hb_cpu_gnt stays high.
- R3: In joined mode, at most one of cpu_gnt and the ext_gnt bits is high in any cycle.
- R4: In split mode, an external request seen while hb_req=0 is granted one clock later. cpu_gnt stays at 1 throughout. While hb_req=1, no new external grant is given.
- R5: In joined mode, when cpu_req=1, pci_retry=1, and a requesting master has its ext_memwr bit set, cpu_boff and that master's ext_gnt rise one clock later, and cpu_gnt drops.
- R6: In joined mode, a request whose ext_memwr bit is 0 gets no grant while cpu_req=1, even during a retry wait. It proceeds through the R2 sequence once cpu_req drops.
- R7: A granted master keeps its grant while its request is high. The grant, cpu_boff and hb_cpu_gnt fall one clock after the request is seen low. The default owners of R1 then return.
- R8: Grants rotate. The next winner is the first requesting index above the last one granted, wrapping around. After reset, index 0 is favoured first.
- R9: A new mode_sel value takes effect only in a clock where no grant to an external master is held and cpu_req, hb_req and every ext_req are 0. Until then the previous mode governs arbitration.
- R10: posting_off is 1 whenever mode_sel or the active mode selects joined mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Requested mode, 1 = joined, 0 = split |
| cpu_req | input | 1 | Processor holds or wants the processor bus |
| hb_req | input | 1 | Bridge master side wants the PCI bus |
| pci_retry | input | 1 | Processor's PCI access is waiting after a retry |
| ext_req | input | N_EXT | Request from each external PCI master |
| ext_memwr | input | N_EXT | Matching request is a memory write |
| cpu_gnt | output | 1 | Processor owns the processor bus |
| hb_cpu_gnt | output | 1 | Bridge owns the processor bus for an external master |
| hb_pci_gnt | output | 1 | Bridge owns the PCI bus |
| ext_gnt | output | N_EXT | PCI bus grant, one-hot, per external master |
| cpu_boff | output | 1 | Forces the processor off its bus |
| posting_off | output | 1 | Disables processor-to-PCI write posting |

## Verification
A behavioural model in the bench is compared with every output on every clock. It is driven through five patterns, and each pattern separates a different class of fault:
- a lone split-mode request, which shows whether the processor's grant is wrongly disturbed;
- three overlapping requests released one at a time, which expose a rotation that repeats or skips an index;
- a mode change issued while a grant is held, which catches a switch that is not deferred;
- joined-mode requests with the processor idle, which check the two-step handover through the bridge;
- a retry wait met first by a read and then by a memory write, which tells a correct backoff apart from one that fires for every request type or never fires.

// File: rtl/dual_bus_arbiter.sv
module dual_bus_arbiter #(
  parameter int N_EXT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             cpu_req,
  input  logic             hb_req,
  input  logic             pci_retry,
  input  logic [N_EXT-1:0] ext_req,
  input  logic [N_EXT-1:0] ext_memwr,
  output logic             cpu_gnt,
  output logic             hb_cpu_gnt,
  output logic             hb_pci_gnt,
  output logic [N_EXT-1:0] ext_gnt,
  output logic             cpu_boff,
  output logic             posting_off
);
  localparam int OW = (N_EXT > 1) ? $clog2(N_EXT) : 1;

  typedef enum logic [2:0] {S_IDLE, S_HAND, S_JOIN, S_BOFF, S_SPLIT} st_t;

  st_t          st;
  logic         joined;
  logic [OW-1:0] own, last;

  function automatic logic [OW-1:0] rr_pick(input logic [N_EXT-1:0] v, input logic [OW-1:0] lst);
    logic [OW-1:0] r;
    int idx;
    r = lst;
    for (int k = N_EXT; k >= 1; k--) begin
      idx = (int'(lst) + k) % N_EXT;
      if (v[idx]) r = OW'(idx);
    end
    return r;
  endfunction

  wire [N_EXT-1:0] wr_req  = ext_req & ext_memwr;
  wire             quiet   = !cpu_req && !hb_req && (ext_req == '0);
  wire             own_req = ext_req[own];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      joined <= 1'b0;
      own    <= '0;
      last   <= OW'(N_EXT - 1);
    end else begin
      case (st)
        S_IDLE: begin
          if (quiet) joined <= mode_sel;
          if (joined) begin
            if (cpu_req && pci_retry && (wr_req != '0)) begin
              own  <= rr_pick(wr_req, last);
              last <= rr_pick(wr_req, last);
              st   <= S_BOFF;
            end else if (!cpu_req && !hb_req && (ext_req != '0)) begin
              own  <= rr_pick(ext_req, last);
              last <= rr_pick(ext_req, last);
              st   <= S_HAND;
            end
          end else if (!hb_req && (ext_req != '0)) begin
            own  <= rr_pick(ext_req, last);
            last <= rr_pick(ext_req, last);
            st   <= S_SPLIT;
          end
        end
        S_HAND:  st <= own_req ? S_JOIN : S_IDLE;
        default: if (!own_req) st <= S_IDLE;
      endcase
    end
  end

  wire ext_on = (st == S_JOIN) || (st == S_BOFF) || (st == S_SPLIT);

  assign cpu_gnt     = (st == S_IDLE) || (st == S_SPLIT);
  assign hb_cpu_gnt  = (st == S_HAND) || (st == S_JOIN) || (st == S_BOFF);
  assign hb_pci_gnt  = (st == S_IDLE) || (st == S_HAND);
  assign ext_gnt     = ext_on ? (N_EXT'(1) << own) : '0;
  assign cpu_boff    = (st == S_BOFF);
  assign posting_off = joined || mode_sel;

  assert_one_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
    joined |-> $onehot0({cpu_gnt, ext_gnt}));

  assert_handover_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (joined && !cpu_boff && $rose(|ext_gnt)) |-> $past(hb_cpu_gnt));

  assert_boff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (joined && cpu_gnt && cpu_req && pci_retry && (wr_req != '0)) |=> (cpu_boff && (ext_gnt != '0)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_gnt & ~ext_req) != '0) |=> ((ext_gnt == '0) && !cpu_boff));

  assert_mode_defer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(joined) |-> $past(ext_gnt == '0 && !hb_cpu_gnt && !cpu_req && !hb_req && ext_req == '0));

  assert_split_cpu_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!joined && !$past(joined)) |-> cpu_gnt);
endmodule

// File: tb/dual_bus_arbiter_bench.sv
`timescale 1ns/1ps
module dual_bus_arbiter_bench;
  localparam int N = 3;

  logic clk = 0, rst_n = 0;
  logic mode_sel = 0, cpu_req = 0, hb_req = 0, pci_retry = 0;
  logic [N-1:0] ext_req = '0, ext_memwr = '0;
  logic cpu_gnt, hb_cpu_gnt, hb_pci_gnt, cpu_boff, posting_off;
  logic [N-1:0] ext_gnt;

  always #2 clk = ~clk;

  dual_bus_arbiter #(.N_EXT(N)) u_dual_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cpu_req(cpu_req),
    .hb_req(hb_req), .pci_retry(pci_retry), .ext_req(ext_req), .ext_memwr(ext_memwr),
    .cpu_gnt(cpu_gnt), .hb_cpu_gnt(hb_cpu_gnt), .hb_pci_gnt(hb_pci_gnt),
    .ext_gnt(ext_gnt), .cpu_boff(cpu_boff), .posting_off(posting_off));

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  // model: phase 0 idle, 1 handover, 2 joined ext, 3 backoff ext, 4 split ext
  int ph = 0, who = 0, prev = N - 1;
  bit m_joined = 0;

  function automatic int choose(input logic [N-1:0] v, input int after);
    for (int k = 1; k <= N; k++)
      if (v[(after + k) % N]) return (after + k) % N;
    return after;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      ph = 0; who = 0; prev = N - 1; m_joined = 0;
    end else if (ph == 0) begin
      if (!cpu_req && !hb_req && ext_req == 0) m_joined = mode_sel;
      else if (m_joined && cpu_req && pci_retry && (ext_req & ext_memwr) != 0) begin
        who = choose(ext_req & ext_memwr, prev); prev = who; ph = 3;
      end else if (m_joined && !cpu_req && !hb_req && ext_req != 0) begin
        who = choose(ext_req, prev); prev = who; ph = 1;
      end else if (!m_joined && !hb_req && ext_req != 0) begin
        who = choose(ext_req, prev); prev = who; ph = 4;
      end
    end else if (ph == 1) ph = ext_req[who] ? 2 : 0;
    else if (!ext_req[who]) ph = 0;
  end

  task automatic cmp(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cmp("cpu_gnt",     cpu_gnt,     (ph == 0 || ph == 4));
    cmp("hb_cpu_gnt",  hb_cpu_gnt,  (ph >= 1 && ph <= 3));
    cmp("hb_pci_gnt",  hb_pci_gnt,  (ph <= 1));
    cmp("ext_gnt",     ext_gnt,     (ph >= 2) ? (1 << who) : 0);
    cmp("cpu_boff",    cpu_boff,    (ph == 3));
    cmp("posting_off", posting_off, (m_joined || mode_sel));
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst_n = 1;
    tag = "R1";  wait_cyc(3);
    tag = "R4";  cpu_req = 1; ext_req = 3'b001; wait_cyc(4);
    tag = "R7";  ext_req = 0; wait_cyc(3);
    tag = "R4";  hb_req = 1; ext_req = 3'b010; wait_cyc(3); hb_req = 0; wait_cyc(3);
    tag = "R8";  ext_req = 3'b111; wait_cyc(3); ext_req = 3'b101; wait_cyc(3);
    ext_req = 3'b001; wait_cyc(3); ext_req = 3'b011; wait_cyc(3); ext_req = 0; cpu_req = 0; wait_cyc(2);
    tag = "R9";  ext_req = 3'b100; wait_cyc(2); mode_sel = 1; wait_cyc(3);
    tag = "R10"; ext_req = 0; wait_cyc(3);
    tag = "R2";  ext_req = 3'b001; wait_cyc(5); ext_req = 0; wait_cyc(2);
    tag = "R3";  ext_req = 3'b110; wait_cyc(4); ext_req = 3'b100; wait_cyc(4); ext_req = 0; wait_cyc(2);
    tag = "R6";  cpu_req = 1; pci_retry = 1; ext_req = 3'b010; wait_cyc(4);
    cpu_req = 0; pci_retry = 0; wait_cyc(4); ext_req = 0; wait_cyc(2);
    tag = "R5";  cpu_req = 1; pci_retry = 1; ext_req = 3'b001; ext_memwr = 3'b001; wait_cyc(4);
    tag = "R7";  ext_req = 0; ext_memwr = 0; wait_cyc(2); pci_retry = 0; wait_cyc(2);
    cpu_req = 0; wait_cyc(2);
    tag = "R9";  mode_sel = 0; cpu_req = 1; wait_cyc(3); cpu_req = 0; wait_cyc(2);
    ext_req = 3'b010; wait_cyc(3); ext_req = 0; wait_cyc(2);
    tag = "R1";  wait_cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule